// File: doc/BRIEF.md
# I2C Master Serial Clock Generator with Clock Synchronization

This block produces the serial clock for an I2C master, whether it is sending or receiving. It drives no logic level directly. Its only line output is a pull-low enable for an open-drain SCL pad, and it watches the sampled SCL level so that it can share the wired-AND clock with other masters and with slaves that stretch the clock.

While master mode is enabled, the generator alternates between two phases:

- A released (mark) phase.
- A pulled-low (space) phase.

Both phases have the same length, set by a selectable rate. Two rates are fixed fractions of the system clock. The third is built from an external timer-overflow pulse. If another device pulls the line low during the mark, the mark ends at once and a full space begins. If the line is still low when the space ends, the generator releases it and waits until it is seen high before it counts a new mark.

A one-cycle strobe marks each phase change, for use by the shift and control logic around the block. When master mode is off, which is the case in every slave mode, the generator sits idle with the line released.

Top module: `i2c_sclgen`

## Requirements
- R1: During reset, and afterwards while master enable is low, `scl_pull_o` and `phase_stb_o` are both 0.
- R2: With `rate_sel_i` = 0, each space lasts exactly 60 system clocks, which is half of a 120-clock period.
- R3: With `rate_sel_i` = 1, each space lasts exactly 4800 system clocks, and a mark with a free line spans 4803 clocks.
- R4: With `rate_sel_i` = 2 or 3, the rate comes from `tmr_ovf_i` pulses. Each space covers exactly 4 overflow pulses, which is half of an 8-pulse period.
- R5: The SCL input passes through two synchronizer flops. With no other device on the line, the line stays released for the half-period plus 3 clocks between spaces (63 clocks at rate 0).
- R6: If SCL is driven low by another device during a mark, `scl_pull_o` rises on the third clock edge after the line falls. A full-length space follows.
- R7: At the end of a space the line is released. While SCL stays low, the generator waits without pulling. After the line is released, the next space starts 63 clocks later at rate 0.
- R8: A change of `rate_sel_i` during a phase leaves that phase's length unchanged. The new rate applies from the next phase boundary.
- R9: Dropping master enable releases the line on the next clock. The line then stays released with no strobe, whatever the other inputs do.
- R10: `phase_stb_o` is high for one clock in the first pulled cycle of each space. It is also high in the first cycle of each mark that follows a space, which is the fourth released cycle.
- R11: Raising master enable starts a mark. With a free line at rate 0, the first pull comes 61 sampled cycles after enable is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | High in master transmit or master receive mode |
| rate_sel_i | input | 2 | 0: clock/120, 1: clock/9600, 2 or 3: overflow pulses/8 |
| tmr_ovf_i | input | 1 | One-cycle timer overflow pulse |
| scl_in_i | input | 1 | Raw level of the SCL line |
| scl_pull_o | output | 1 | High enables the open-drain pull-down on SCL |
| phase_stb_o | output | 1 | One-cycle strobe on each mark/space change |

## Verification
The hardest state to reach from the ports is the wait state: the block's own space has ended but another device still holds the line low. Reaching it depends on the synchronizer delay, the model of the wired line, and the end of the space all falling in the right cycles.

The bench models the line as the AND of the block's release and an external pull. It pulls the line low partway through a mark, which forces an early space, and keeps holding it past the end of that space. This places the generator in the wait state with a known history. The bench then releases the line and measures when the new mark and its strobe begin.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_MARK  = 2'd1,
      PH_SPACE = 2'd2,
      PH_WAIT  = 2'd3
   } sclgen_phase_e;

   typedef enum logic [1:0] {
      RATE_FAST    = 2'd0,
      RATE_SLOW    = 2'd1,
      RATE_TMR     = 2'd2,
      RATE_TMR_ALT = 2'd3
   } sclgen_rate_e;
endpackage

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   // Reset to 1: an idle bus is high.
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sclgen_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sclgen_rate.sv
module sclgen_rate
   import i2c_sclgen_pkg::*;
#(
   parameter int FAST_HALF = 60,
   parameter int SLOW_HALF = 4800,
   parameter int TMR_HALF  = 4,
   parameter int CNT_W     = 13
) (
   input  sclgen_rate_e     rate_q_i,
   input  logic             tmr_ovf_i,
   output logic             tick_o,
   output logic [CNT_W-1:0] last_o
);
   localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);
   localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);
   localparam logic [CNT_W-1:0] TMR_LAST  = CNT_W'(TMR_HALF - 1);

   always_comb begin
      case (rate_q_i)
         RATE_FAST:    begin tick_o = 1'b1;      last_o = FAST_LAST; end
         RATE_SLOW:    begin tick_o = 1'b1;      last_o = SLOW_LAST; end
         RATE_TMR:     begin tick_o = tmr_ovf_i; last_o = TMR_LAST;  end
         RATE_TMR_ALT: begin tick_o = tmr_ovf_i; last_o = TMR_LAST;  end
         default:      begin tick_o = 1'b1;      last_o = FAST_LAST; end
      endcase
   end
endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
   import i2c_sclgen_pkg::*;
#(
   parameter int CNT_W = 13
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [1:0]       rate_sel_i,
   input  logic             scl_s_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] last_i,
   output sclgen_rate_e     rate_q_o,
   output logic             scl_pull_o,
   output logic             phase_stb_o
);
   sclgen_phase_e    ph_q;
   logic [CNT_W-1:0] cnt_q;
   sclgen_rate_e     rate_q;
   logic             stb_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         rate_q <= RATE_FAST;
         stb_q  <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (!en_i) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
         end else begin
            case (ph_q)
               PH_IDLE: begin
                  ph_q   <= PH_MARK;
                  cnt_q  <= '0;
                  rate_q <= sclgen_rate_e'(rate_sel_i);
               end
               PH_MARK: begin
                  // Early low from another device, or mark count done.
                  if (!scl_s_i || (tick_i && cnt_q == last_i)) begin
                     ph_q   <= PH_SPACE;
                     cnt_q  <= '0;
                     rate_q <= sclgen_rate_e'(rate_sel_i);
                     stb_q  <= 1'b1;
                  end else if (tick_i) begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               PH_SPACE: begin
                  if (tick_i) begin
                     if (cnt_q == last_i) begin
                        ph_q  <= PH_WAIT;
                        cnt_q <= '0;
                     end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                     end
                  end
               end
               PH_WAIT: begin
                  // Counter held until the line is seen high.
                  if (scl_s_i) begin
                     ph_q   <= PH_MARK;
                     cnt_q  <= '0;
                     rate_q <= sclgen_rate_e'(rate_sel_i);
                     stb_q  <= 1'b1;
                  end
               end
               default: ph_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign rate_q_o    = rate_q;
   assign scl_pull_o  = (ph_q == PH_SPACE);
   assign phase_stb_o = stb_q;

   AST_SLAVE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!scl_pull_o && !phase_stb_o)); // R9

   AST_EARLY_LOW_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && ph_q == PH_MARK && !scl_s_i) |=> (ph_q == PH_SPACE)); // R6

   AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && ph_q == PH_WAIT && !scl_s_i) |=> (ph_q == PH_WAIT && !scl_pull_o && cnt_q == '0)); // R7

   AST_STB_ON_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(scl_pull_o) |-> phase_stb_o); // R10

   AST_SPACE_RATE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_SPACE && $past(ph_q) == PH_SPACE) |-> $stable(rate_q)); // R8

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q != PH_IDLE) |-> (cnt_q <= last_i)); // R2
endmodule

// File: rtl/i2c_sclgen.sv
module i2c_sclgen
   import i2c_sclgen_pkg::*;
#(
   parameter int FAST_HALF   = 60,
   parameter int SLOW_HALF   = 4800,
   parameter int TMR_HALF    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       master_en_i,
   input  logic [1:0] rate_sel_i,
   input  logic       tmr_ovf_i,
   input  logic       scl_in_i,
   output logic       scl_pull_o,
   output logic       phase_stb_o
);
   localparam int MAX_A    = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
   localparam int MAX_HALF = (MAX_A > TMR_HALF) ? MAX_A : TMR_HALF;
   localparam int CNT_W    = $clog2(MAX_HALF + 1);

   generate
      if (FAST_HALF < 1 || SLOW_HALF < 1 || TMR_HALF < 1) begin : g_bad_half
         $error("i2c_sclgen: every half-period must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_sclgen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             scl_s;
   logic             tick;
   logic [CNT_W-1:0] last;
   sclgen_rate_e     rate_q;

   sclgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (scl_in_i),
      .q_o   (scl_s)
   );

   sclgen_rate #(
      .FAST_HALF(FAST_HALF),
      .SLOW_HALF(SLOW_HALF),
      .TMR_HALF (TMR_HALF),
      .CNT_W    (CNT_W)
   ) u_rate (
      .rate_q_i (rate_q),
      .tmr_ovf_i(tmr_ovf_i),
      .tick_o   (tick),
      .last_o   (last)
   );

   sclgen_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (master_en_i),
      .rate_sel_i (rate_sel_i),
      .scl_s_i    (scl_s),
      .tick_i     (tick),
      .last_i     (last),
      .rate_q_o   (rate_q),
      .scl_pull_o (scl_pull_o),
      .phase_stb_o(phase_stb_o)
   );
endmodule

// File: tb/sim_i2c_sclgen.sv
module sim_i2c_sclgen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [1:0] rate = 2'd0;
   logic       ovf = 1'b0;
   logic       ext_low = 1'b0;
   logic       ovf_on = 1'b0;
   logic       scl_line;
   logic       pull;
   logic       stb;
   int         n_chk = 0;
   int         n_bad = 0;

   assign scl_line = ~(pull | ext_low);

   i2c_sclgen u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .master_en_i(en),
      .rate_sel_i (rate),
      .tmr_ovf_i  (ovf),
      .scl_in_i   (scl_line),
      .scl_pull_o (pull),
      .phase_stb_o(stb)
   );

   initial forever #10 clk = ~clk;

   // Timer overflow source: one pulse every 7 clocks while enabled.
   initial begin
      int k = 0;
      forever begin
         @(posedge clk); #1;
         ovf = ovf_on && (k % 7 == 0);
         k++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drv();
      @(posedge clk); #1;
   endtask

   // Call at a negedge; counts samples while pull == val.
   task automatic run(input logic val, output int n, output int stb_pos, output int novf);
      n = 0; stb_pos = -1; novf = 0;
      while (pull == val && n < 20000) begin
         if (stb && stb_pos < 0) stb_pos = n;
         if (ovf) novf++;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_reset(input logic [1:0] r);
      drv();
      rst_n = 1'b0; en = 1'b0; ext_low = 1'b0; ovf_on = 1'b0; rate = r;
      repeat (3) drv();
      rst_n = 1'b1;
      drv();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(pull == 1'b0 && stb == 1'b0, "R1 in reset", int'(pull), 0);
      drv(); rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(pull == 1'b0 && stb == 1'b0, "R1 idle after reset", int'(pull), 0);
   endtask

   task automatic t_fast();
      int n, sp, no;
      do_reset(2'd0);
      en = 1'b1;
      @(negedge clk);
      run(1'b0, n, sp, no);
      chk(n == 61, "R11 first mark", n, 61);
      chk(stb == 1'b1, "R10 strobe at space start", int'(stb), 1);
      run(1'b1, n, sp, no);
      chk(n == 60, "R2 space length", n, 60);
      run(1'b0, n, sp, no);
      chk(n == 63, "R5 released span", n, 63);
      chk(sp == 3, "R10 strobe at mark start", sp, 3);
      run(1'b1, n, sp, no);
      chk(n == 60, "R2 second space", n, 60);
   endtask

   task automatic t_early_and_wait();
      int n, sp, no;
      do_reset(2'd0);
      en = 1'b1;
      @(negedge clk);
      run(1'b0, n, sp, no);
      run(1'b1, n, sp, no);
      repeat (20) @(negedge clk);
      drv(); ext_low = 1'b1;
      @(negedge clk);
      run(1'b0, n, sp, no);
      chk(n == 3, "R6 early low reaction", n, 3);
      chk(stb == 1'b1, "R6 strobe on forced space", int'(stb), 1);
      run(1'b1, n, sp, no);
      chk(n == 60, "R6 full space after early low", n, 60);
      begin
         int pulled = 0;
         repeat (100) begin
            @(negedge clk);
            if (pull) pulled++;
         end
         chk(pulled == 0, "R7 no pull while held low", pulled, 0);
      end
      drv(); ext_low = 1'b0;
      @(negedge clk);
      run(1'b0, n, sp, no);
      chk(n == 63, "R7 mark after release", n, 63);
      chk(sp == 3, "R7 strobe after release", sp, 3);
   endtask

   task automatic t_rate_change();
      int n, sp, no;
      do_reset(2'd0);
      en = 1'b1;
      @(negedge clk);
      run(1'b0, n, sp, no);
      drv(); rate = 2'd1;
      @(negedge clk);
      run(1'b1, n, sp, no);
      chk(n == 59, "R8 space unchanged by rate switch", n, 59);
      run(1'b0, n, sp, no);
      chk(n == 4803, "R3 slow mark", n, 4803);
      run(1'b1, n, sp, no);
      chk(n == 4800, "R3 slow space", n, 4800);
   endtask

   task automatic t_timer(input logic [1:0] r);
      int n, sp, no;
      do_reset(r);
      ovf_on = 1'b1;
      en = 1'b1;
      @(negedge clk);
      run(1'b0, n, sp, no);
      run(1'b1, n, sp, no);
      chk(no == 4, "R4 overflow pulses in space", no, 4);
      run(1'b0, n, sp, no);
      run(1'b1, n, sp, no);
      chk(no == 4, "R4 overflow pulses in next space", no, 4);
      ovf_on = 1'b0;
   endtask

   task automatic t_disable();
      int n, sp, no;
      do_reset(2'd2);
      ovf_on = 1'b1;
      rate = 2'd0;
      en = 1'b1;
      @(negedge clk);
      run(1'b0, n, sp, no);
      drv(); en = 1'b0;
      @(negedge clk);
      begin
         int active = 0;
         rate = 2'd2;
         repeat (300) begin
            @(negedge clk);
            if (pull || stb) active++;
         end
         chk(active == 0, "R9 quiet when disabled", active, 0);
      end
      ovf_on = 1'b0;
      drv(); rate = 2'd0; en = 1'b1;
      @(negedge clk);
      run(1'b0, n, sp, no);
      chk(n == 61, "R11 restart after enable", n, 61);
   endtask

   initial begin
      t_reset();
      t_fast();
      t_early_and_wait();
      t_rate_change();
      t_timer(2'd2);
      t_timer(2'd3);
      t_disable();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule